// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block couples two eight-bit buses, A and B, through a pair of independent one-way paths. Each path has a capture register with its own load strobe, a source select and an output enable. The A-to-B enable is active high and the B-to-A enable is active low. The select picks, per direction, what a driving port carries. In real-time mode it carries live data from the opposite bus. In storage mode it carries the value held in that direction's register. The two paths are controlled separately, so software or a neighbouring controller can isolate the buses, snapshot either bus, replay a stored word, or pass data straight through in either direction.

Each port is modelled as a separate input, output and drive-enable, never as a tri-state pin. The effective value of a bus is its external input while the block does not drive it, and the block's own output while it does. A load strobe samples that effective value at the next rising edge of the system clock. Loading happens whatever the selects and enables are set to.

Both directions can be enabled in real-time mode at the same time. On a physical wire each output would then reinforce its own input. Here that case is resolved by a hold register. It keeps the A-bus value from the last cycle before the loop closed and shows it on both buses for as long as the loop stays closed.

Top module: `dual_reg_xcvr`

## Requirements
- R1: After asynchronous reset (rst_n low), both capture registers read zero. Enabling both directions in storage mode then drives 0x00 on both outputs.
- R2: When ab_load is high at a rising clock edge, the A-to-B register takes the effective A-bus value, and ba_load does the same for the B-to-A register with the B bus. This happens whatever the selects and enables are, and a register with its strobe low keeps its value.
- R3: b_oe equals ab_en (active high) and a_oe equals the inverse of ba_en_n (active low). An output whose drive-enable is low reads 0x00.
- R4: With ab_en=1, ab_sel_store=0 and A not driven (ba_en_n=1), b_out equals a_in in the same cycle.
- R5: With ab_en=1 and ab_sel_store=1, b_out equals the A-to-B register, independent of a_in.
- R6: With ba_en_n=0 and ba_sel_store=0 and B not driven (ab_en=0), a_out equals b_in in the same cycle. With ba_sel_store=1, a_out equals the B-to-A register.
- R7: In isolation (ab_en=0, ba_en_n=1), neither output drives, and either register can still be loaded from its own bus input.
- R8: While A-to-B is enabled in real-time mode, ba_load stores the a_in value into the B-to-A register, so one bus word can be written into both registers.
- R9: With both directions enabled and both selects low, both outputs drive the A-bus value of the cycle before the loop closed. They keep that value while the loop stays closed, whatever a_in and b_in do.
- R10: With both directions enabled and both selects high, b_out carries the A-to-B register and a_out carries the B-to-A register at the same time.
- R11: When the block drives bus A, ab_load captures the driven A value rather than a_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; loads act on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ab_load | input | 1 | Load strobe of the A-to-B register |
| ba_load | input | 1 | Load strobe of the B-to-A register |
| ab_sel_store | input | 1 | A-to-B source: 0 live A bus, 1 stored register |
| ba_sel_store | input | 1 | B-to-A source: 0 live B bus, 1 stored register |
| ab_en | input | 1 | A-to-B output enable, active high |
| ba_en_n | input | 1 | B-to-A output enable, active low |
| a_in | input | 8 | External value seen on bus A |
| a_out | output | 8 | Value the block drives onto bus A |
| a_oe | output | 1 | Drive-enable for bus A |
| b_in | input | 8 | External value seen on bus B |
| b_out | output | 8 | Value the block drives onto bus B |
| b_oe | output | 1 | Drive-enable for bus B |

## Verification
The hardest situation to reach is the closed real-time loop, because the value it holds depends on the cycle before closure and not on any input present while it is closed. The stimulus first passes a known word from A to B in real time for a full clock edge. It then enables B-to-A with its select low, and changes both external inputs to unrelated values. The outputs are checked over several cycles, and a load strobe is fired while the loop is closed. Opening the loop into storage mode then shows that the captured word was the held value.

// File: rtl/dual_reg_xcvr_pkg.sv
package dual_reg_xcvr_pkg;

    // Where the value seen on one bus comes from.
    typedef enum logic [2:0] {
        SRC_OWN_PIN  = 3'd0,  // bus not driven: external input
        SRC_INTO_REG = 3'd1,  // driven from the register feeding this bus
        SRC_FAR_PIN  = 3'd2,  // driven live from the far bus, which is undriven
        SRC_FAR_REG  = 3'd3,  // driven live from the far bus, which carries its register
        SRC_HOLD     = 3'd4   // both live paths closed on each other
    } bus_src_e;

    function automatic bus_src_e resolve_src(
        input logic drive_here,
        input logic store_into_here,
        input logic drive_far,
        input logic store_into_far
    );
        bus_src_e s;
        if (!drive_here)          s = SRC_OWN_PIN;
        else if (store_into_here) s = SRC_INTO_REG;
        else if (!drive_far)      s = SRC_FAR_PIN;
        else if (store_into_far)  s = SRC_FAR_REG;
        else                      s = SRC_HOLD;
        return s;
    endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
    } cap_state_t;

    cap_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) state_d.data = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign q = state_q.data;

    // R2: a strobe stores the presented word, no strobe keeps the old one
    p_load_takes_d_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));
    p_idle_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/xcvr_bus_view.sv
module xcvr_bus_view
    import dual_reg_xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             drive_here,
    input  logic             store_into_here,
    input  logic             drive_far,
    input  logic             store_into_far,
    input  logic [WIDTH-1:0] own_pin,
    input  logic [WIDTH-1:0] far_pin,
    input  logic [WIDTH-1:0] reg_into_here,
    input  logic [WIDTH-1:0] reg_into_far,
    input  logic [WIDTH-1:0] hold_val,
    output logic [WIDTH-1:0] bus_val,
    output logic [WIDTH-1:0] pin_out
);
    bus_src_e src;

    always_comb begin
        src = resolve_src(drive_here, store_into_here, drive_far, store_into_far);
        unique case (src)
            SRC_OWN_PIN:  bus_val = own_pin;
            SRC_INTO_REG: bus_val = reg_into_here;
            SRC_FAR_PIN:  bus_val = far_pin;
            SRC_FAR_REG:  bus_val = reg_into_far;
            default:      bus_val = hold_val;
        endcase
        pin_out = drive_here ? bus_val : '0;
    end
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ab_load,
    input  logic             ba_load,
    input  logic             ab_sel_store,
    input  logic             ba_sel_store,
    input  logic             ab_en,
    input  logic             ba_en_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    logic             drv_a, drv_b, loop_closed;
    logic [WIDTH-1:0] a_bus, b_bus;
    logic [WIDTH-1:0] ab_q, ba_q, hold_q;

    assign drv_b       = ab_en;
    assign drv_a       = ~ba_en_n;
    assign loop_closed = drv_a & drv_b & ~ab_sel_store & ~ba_sel_store;
    assign a_oe        = drv_a;
    assign b_oe        = drv_b;

    xcvr_capture_reg #(.WIDTH(WIDTH)) u_ab_reg (
        .clk(clk), .rst_n(rst_n), .load(ab_load), .d(a_bus), .q(ab_q));

    xcvr_capture_reg #(.WIDTH(WIDTH)) u_ba_reg (
        .clk(clk), .rst_n(rst_n), .load(ba_load), .d(b_bus), .q(ba_q));

    // Follows the A bus while the loop is open and freezes once it closes.
    xcvr_capture_reg #(.WIDTH(WIDTH)) u_hold_reg (
        .clk(clk), .rst_n(rst_n), .load(~loop_closed), .d(a_bus), .q(hold_q));

    xcvr_bus_view #(.WIDTH(WIDTH)) u_view_a (
        .drive_here(drv_a), .store_into_here(ba_sel_store),
        .drive_far(drv_b), .store_into_far(ab_sel_store),
        .own_pin(a_in), .far_pin(b_in),
        .reg_into_here(ba_q), .reg_into_far(ab_q),
        .hold_val(hold_q), .bus_val(a_bus), .pin_out(a_out));

    xcvr_bus_view #(.WIDTH(WIDTH)) u_view_b (
        .drive_here(drv_b), .store_into_here(ab_sel_store),
        .drive_far(drv_a), .store_into_far(ba_sel_store),
        .own_pin(b_in), .far_pin(a_in),
        .reg_into_here(ab_q), .reg_into_far(ba_q),
        .hold_val(hold_q), .bus_val(b_bus), .pin_out(b_out));

    // R3: an undriven port outputs zero
    p_quiet_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_en |-> (b_out == '0 && !b_oe));
    p_quiet_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ba_en_n |-> (a_out == '0 && !a_oe));
    // R4: live A to B pass-through
    p_live_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_en && !ab_sel_store && ba_en_n) |-> (b_out == a_in));
    // R6: live B to A pass-through
    p_live_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_en_n && !ba_sel_store && !ab_en) |-> (a_out == b_in));
    // R5: a stored word stays put on B while no load occurs
    p_store_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_en && ab_sel_store && $past(ab_en && ab_sel_store) && !$past(ab_load))
        |-> $stable(b_out));
    // R9: closed loop holds one value on both buses
    p_loop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_closed && $past(loop_closed)) |-> ($stable(a_out) && a_out == b_out));
endmodule

// File: tb/dual_reg_xcvr_tb.sv
module dual_reg_xcvr_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ab_load = 1'b0, ba_load = 1'b0;
    logic         ab_sel_store = 1'b0, ba_sel_store = 1'b0;
    logic         ab_en = 1'b0, ba_en_n = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int checks = 0;
    int fails  = 0;
    bit summary_done = 1'b0;

    always #10 clk = ~clk;

    dual_reg_xcvr #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ab_load(ab_load), .ba_load(ba_load),
        .ab_sel_store(ab_sel_store), .ba_sel_store(ba_sel_store),
        .ab_en(ab_en), .ba_en_n(ba_en_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Inputs change at the falling edge; outputs are sampled 5 ns later.
    task automatic settle();
        #5;
    endtask

    task automatic next_cycle();
        @(negedge clk);
    endtask

    task automatic set_ctrl(input logic en_ab, input logic en_ba_n,
                            input logic s_ab, input logic s_ba);
        ab_en = en_ab; ba_en_n = en_ba_n; ab_sel_store = s_ab; ba_sel_store = s_ba;
    endtask

    task automatic pulse_load(input logic la, input logic lb);
        ab_load = la; ba_load = lb;
        next_cycle();
        ab_load = 1'b0; ba_load = 1'b0;
    endtask

    task automatic t_reset();
        next_cycle();
        set_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
        a_in = 8'hA5; b_in = 8'h5A;
        settle();
        chk("R1 b_out after reset", b_out, 8'h00);
        chk("R1 a_out after reset", a_out, 8'h00);
    endtask

    task automatic t_enables();
        next_cycle();
        set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
        a_in = 8'h33; b_in = 8'h44;
        settle();
        chk("R3 b_oe low", {7'd0, b_oe}, 8'h00);
        chk("R3 a_oe low", {7'd0, a_oe}, 8'h00);
        chk("R3 b_out quiet", b_out, 8'h00);
        chk("R3 a_out quiet", a_out, 8'h00);
        next_cycle();
        set_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
        settle();
        chk("R3 b_oe high", {7'd0, b_oe}, 8'h01);
        chk("R3 a_oe high", {7'd0, a_oe}, 8'h01);
    endtask

    task automatic t_live_ab();
        next_cycle();
        set_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        a_in = 8'h12;
        settle();
        chk("R4 live 0x12", b_out, 8'h12);
        next_cycle();
        a_in = 8'hED;
        settle();
        chk("R4 live 0xED", b_out, 8'hED);
    endtask

    task automatic t_live_ba();
        next_cycle();
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
        b_in = 8'h6C;
        settle();
        chk("R6 live B to A", a_out, 8'h6C);
    endtask

    task automatic t_isolation_store();
        next_cycle();
        set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
        a_in = 8'h81; b_in = 8'h7E;
        pulse_load(1'b1, 1'b1);
        a_in = 8'h00; b_in = 8'hFF;
        settle();
        chk("R7 isolation a_oe", {7'd0, a_oe}, 8'h00);
        chk("R7 isolation b_oe", {7'd0, b_oe}, 8'h00);
        next_cycle();
        set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
        settle();
        chk("R5 R7 stored A replayed", b_out, 8'h81);
        next_cycle();
        a_in = 8'h42;
        settle();
        chk("R5 ignores a_in", b_out, 8'h81);
        next_cycle();
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b1);
        settle();
        chk("R6 R7 stored B replayed", a_out, 8'h7E);
    endtask

    task automatic t_no_load_keeps();
        next_cycle();
        set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
        a_in = 8'hC3; b_in = 8'h3C;
        next_cycle();
        next_cycle();
        set_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
        settle();
        chk("R2 AB kept without load", b_out, 8'h81);
        chk("R2 BA kept without load", a_out, 8'h7E);
    endtask

    task automatic t_dual_store();
        next_cycle();
        set_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        a_in = 8'h9B; b_in = 8'h11;
        pulse_load(1'b1, 1'b1);
        set_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
        a_in = 8'h00; b_in = 8'h00;
        settle();
        chk("R8 AB holds A word", b_out, 8'h9B);
        chk("R8 BA holds A word", a_out, 8'h9B);
    endtask

    task automatic t_both_store();
        next_cycle();
        set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
        a_in = 8'h5F; b_in = 8'hA0;
        pulse_load(1'b1, 1'b1);
        set_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
        a_in = 8'hFF; b_in = 8'hFF;
        settle();
        chk("R10 stored A on B", b_out, 8'h5F);
        chk("R10 stored B on A", a_out, 8'hA0);
    endtask

    task automatic t_capture_driven();
        next_cycle();
        set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
        b_in = 8'h3D;
        pulse_load(1'b0, 1'b1);
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b1);
        a_in = 8'h99;
        pulse_load(1'b1, 1'b0);
        set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
        a_in = 8'h00;
        settle();
        chk("R11 AB took driven A", b_out, 8'h3D);
    endtask

    task automatic t_loop_hold();
        next_cycle();
        set_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        a_in = 8'h5A; b_in = 8'h00;
        next_cycle();
        set_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
        a_in = 8'hFF; b_in = 8'h0F;
        settle();
        chk("R9 loop B value", b_out, 8'h5A);
        chk("R9 loop A value", a_out, 8'h5A);
        next_cycle();
        a_in = 8'h01; b_in = 8'h80;
        ab_load = 1'b1;
        next_cycle();
        ab_load = 1'b0;
        next_cycle();
        settle();
        chk("R9 loop still held", b_out, 8'h5A);
        next_cycle();
        set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
        settle();
        chk("R9 R2 load during loop took held value", b_out, 8'h5A);
    endtask

    initial begin
        #(20 * 5000);
        if (!summary_done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary_done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enables();
        t_live_ab();
        t_live_ba();
        t_isolation_store();
        t_no_load_keeps();
        t_dual_store();
        t_both_store();
        t_capture_driven();
        t_loop_hold();
        next_cycle();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end
endmodule